// File: doc/BRIEF.md
# Direct-Color Pixel Bus Serializer

This block sits between a wide pixel memory bus and the per-pixel colour path of a display pipeline. It accepts one bus load at a time. The load is 16, 32 or 64 bits wide and holds one, two or four 16-bit pixels. The block then issues those pixels one per clock. Each 16-bit word is split into red, green and blue fields. Each field is widened to 8 bits by copying its top bits into the empty low bits. Where the chosen layout carries overlay bits, they come out on a separate output.

Two 8-bit control codes set the operation. The format code picks one of four 16-bit layouts, and the multiplex code picks the bus width. A separate input picks the order of pixels within a load: lowest lane first or highest lane first. A new load is taken only while `load_ready` is high. That is the case when the block is idle, or when it is showing the last pixel of the current load, so loads can follow one another with no idle cycle. If the pair of codes is not supported, every output goes to zero and `cfg_err` is raised.

Top module: `dc_pixel_serializer`

## Requirements
- R1: After reset, `pix_valid` is 0. Once reset has been released and synchronised, `load_ready` is 1 when the codes are valid.
- R2: Format code 0x05 (5-6-5): red = word[15:11], green = word[10:5], blue = word[4:0]. Overlay output is 0.
- R3: Format code 0x04 (1-5-5-5): overlay[0] = word[15], overlay[3:1] = 0, red = word[14:10], green = word[9:5], blue = word[4:0].
- R4: Format code 0x03 (6-6-4): red = word[15:10], green = word[9:4], blue = word[3:0]. Overlay output is 0.
- R5: Format code 0x01 (4-4-4-4): red = word[15:12], green = word[11:8], blue = word[7:4], overlay = word[3:0].
- R6: Multiplex code 0x52 gives 1 pixel per load from load_data[15:0]. Code 0x53 gives 2 pixels from load_data[31:0]. Code 0x54 gives 4 pixels from load_data[63:0]. Bits above the active width are ignored.
- R7: With `big_endian` = 0, pixel k of a load is load_data[16k+15:16k].
- R8: With `big_endian` = 1, pixel k of an N-pixel load is lane N-1-k, so the highest active lane comes out first.
- R9: `load_ready` is high when the block is idle or showing the last pixel of a load, and low otherwise. A load is taken on a clock edge where `load_valid` and `load_ready` are both high. While `load_ready` is low, `load_data` has no effect on the pixels produced.
- R10: The first pixel of a load appears with `pix_valid` = 1 in the cycle after the load is taken. The remaining pixels follow in consecutive cycles. `pix_valid` drops after the last pixel unless a new load was taken.
- R11: An unsupported format or multiplex code sets `cfg_err`. While it is set, `pix_valid`, `load_ready`, red, green, blue and overlay are all 0. Any pixels not yet sent from the current load are dropped.
- R12: Each colour field of width w is widened to 8 bits as {field, field's top 8-w bits}. A 4-bit field becomes {f, f}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fmt_code | input | 8 | Colour layout code (0x05, 0x04, 0x03, 0x01) |
| mux_code | input | 8 | Bus width code (0x52, 0x53, 0x54) |
| big_endian | input | 1 | 1: highest lane first, 0: lowest lane first |
| load_valid | input | 1 | A bus load is offered |
| load_data | input | 64 | Bus load contents |
| load_ready | output | 1 | A load can be taken on this edge |
| pix_valid | output | 1 | Colour outputs hold a pixel |
| red | output | 8 | Widened red field |
| green | output | 8 | Widened green field |
| blue | output | 8 | Widened blue field |
| overlay | output | 4 | Overlay bits, zero-extended |
| cfg_err | output | 1 | Unsupported code pair |

## Verification
Each of the four layouts is run with all three bus widths and both lane orders. The lanes of each load hold distinct words, so a wrong lane, a reversed order, or a swapped or shifted field produces a different colour triple. Junk is placed above the active bus width to show that those bits are ignored. All-ones and all-zero words test the widening at its extremes. A four-pixel load is then traced cycle by cycle, with `load_data` changed while `load_ready` is low. The run ends with bad codes, one of them raised mid-load, to show that the outputs go to zero and the remaining pixels are dropped.

// File: rtl/dcps_pkg.sv
package dcps_pkg;

  typedef enum logic [1:0] {
    FMT_565  = 2'd0,
    FMT_1555 = 2'd1,
    FMT_664  = 2'd2,
    FMT_4444 = 2'd3
  } pix_fmt_e;

  localparam logic [7:0] FCODE_565  = 8'h05;
  localparam logic [7:0] FCODE_1555 = 8'h04;
  localparam logic [7:0] FCODE_664  = 8'h03;
  localparam logic [7:0] FCODE_4444 = 8'h01;

  localparam logic [7:0] MCODE_X1 = 8'h52;
  localparam logic [7:0] MCODE_X2 = 8'h53;
  localparam logic [7:0] MCODE_X4 = 8'h54;

  typedef struct packed {
    logic [7:0] r;
    logic [7:0] g;
    logic [7:0] b;
    logic [3:0] ovl;
  } pix_out_t;

endpackage

// File: rtl/dcps_mode_decode.sv
module dcps_mode_decode
  import dcps_pkg::*;
#(
  parameter int MAX_LANES = 4,
  parameter int IDX_W     = 2
) (
  input  logic [7:0]       fmt_code,
  input  logic [7:0]       mux_code,
  output pix_fmt_e         fmt,
  output logic [IDX_W-1:0] lanes_m1,
  output logic             cfg_err
);

  logic       fmt_ok;
  logic       mux_ok;
  logic [3:0] lane_cnt;

  always_comb begin
    fmt_ok = 1'b1;
    case (fmt_code)
      FCODE_565:  fmt = FMT_565;
      FCODE_1555: fmt = FMT_1555;
      FCODE_664:  fmt = FMT_664;
      FCODE_4444: fmt = FMT_4444;
      default: begin
        fmt    = FMT_565;
        fmt_ok = 1'b0;
      end
    endcase
  end

  always_comb begin
    mux_ok = 1'b1;
    case (mux_code)
      MCODE_X1: lane_cnt = 4'd1;
      MCODE_X2: lane_cnt = 4'd2;
      MCODE_X4: lane_cnt = 4'd4;
      default: begin
        lane_cnt = 4'd1;
        mux_ok   = 1'b0;
      end
    endcase
    if (int'(lane_cnt) > MAX_LANES) mux_ok = 1'b0;
  end

  assign lanes_m1 = mux_ok ? IDX_W'(lane_cnt - 4'd1) : '0;
  assign cfg_err  = !(fmt_ok && mux_ok);

endmodule

// File: rtl/dcps_lane_select.sv
module dcps_lane_select #(
  parameter int BUS_W     = 64,
  parameter int PIX_W     = 16,
  parameter int MAX_LANES = BUS_W / PIX_W,
  parameter int IDX_W     = 2
) (
  input  logic [BUS_W-1:0] data,
  input  logic [IDX_W-1:0] idx,
  input  logic [IDX_W-1:0] lanes_m1,
  input  logic             big_endian,
  output logic [PIX_W-1:0] word
);

  logic [PIX_W-1:0] lane_w [MAX_LANES];
  logic [IDX_W-1:0] sel;

  for (genvar i = 0; i < MAX_LANES; i++) begin : g_lane
    assign lane_w[i] = data[i*PIX_W +: PIX_W];
  end

  assign sel  = big_endian ? IDX_W'(lanes_m1 - idx) : idx;
  assign word = lane_w[sel];

endmodule

// File: rtl/dcps_field_expand.sv
module dcps_field_expand
  import dcps_pkg::*;
(
  input  pix_fmt_e    fmt,
  input  logic [15:0] word,
  output pix_out_t    px
);

  function automatic logic [7:0] wid6(input logic [5:0] v);
    return {v, v[5:4]};
  endfunction

  function automatic logic [7:0] wid5(input logic [4:0] v);
    return {v, v[4:2]};
  endfunction

  function automatic logic [7:0] wid4(input logic [3:0] v);
    return {v, v};
  endfunction

  always_comb begin
    px = '0;
    case (fmt)
      FMT_565: begin
        px.r = wid5(word[15:11]);
        px.g = wid6(word[10:5]);
        px.b = wid5(word[4:0]);
      end
      FMT_1555: begin
        px.ovl = {3'b000, word[15]};
        px.r   = wid5(word[14:10]);
        px.g   = wid5(word[9:5]);
        px.b   = wid5(word[4:0]);
      end
      FMT_664: begin
        px.r = wid6(word[15:10]);
        px.g = wid6(word[9:4]);
        px.b = wid4(word[3:0]);
      end
      default: begin
        px.r   = wid4(word[15:12]);
        px.g   = wid4(word[11:8]);
        px.b   = wid4(word[7:4]);
        px.ovl = word[3:0];
      end
    endcase
  end

endmodule

// File: rtl/dc_pixel_serializer.sv
module dc_pixel_serializer
  import dcps_pkg::*;
#(
  parameter int BUS_W = 64,
  parameter int PIX_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       fmt_code,
  input  logic [7:0]       mux_code,
  input  logic             big_endian,
  input  logic             load_valid,
  input  logic [BUS_W-1:0] load_data,
  output logic             load_ready,
  output logic             pix_valid,
  output logic [7:0]       red,
  output logic [7:0]       green,
  output logic [7:0]       blue,
  output logic [3:0]       overlay,
  output logic             cfg_err
);

  localparam int MAX_LANES = BUS_W / PIX_W;
  localparam int IDX_W     = (MAX_LANES > 1) ? $clog2(MAX_LANES) : 1;

  // reset synchroniser: asserts at once, releases on the clock
  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  pix_fmt_e         fmt;
  logic [IDX_W-1:0] lanes_m1;
  logic             err;

  dcps_mode_decode #(.MAX_LANES(MAX_LANES), .IDX_W(IDX_W)) u_dec (
    .fmt_code (fmt_code),
    .mux_code (mux_code),
    .fmt      (fmt),
    .lanes_m1 (lanes_m1),
    .cfg_err  (err)
  );

  // sequencing state
  logic             busy_q, busy_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [BUS_W-1:0] data_q;
  logic             last, take;

  assign last       = busy_q && (idx_q == lanes_m1);
  assign load_ready = rst_i_n && !err && (!busy_q || last);
  assign take       = load_valid && load_ready;

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    if (err) begin
      busy_d = 1'b0;
      idx_d  = '0;
    end else if (take) begin
      busy_d = 1'b1;
      idx_d  = '0;
    end else if (last) begin
      busy_d = 1'b0;
      idx_d  = '0;
    end else if (busy_q) begin
      idx_d  = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)  data_q <= '0;
    else if (take) data_q <= load_data;
  end

  logic [PIX_W-1:0] word;
  pix_out_t         px;

  dcps_lane_select #(
    .BUS_W(BUS_W), .PIX_W(PIX_W), .MAX_LANES(MAX_LANES), .IDX_W(IDX_W)
  ) u_sel (
    .data       (data_q),
    .idx        (idx_q),
    .lanes_m1   (lanes_m1),
    .big_endian (big_endian),
    .word       (word)
  );

  dcps_field_expand u_exp (
    .fmt  (fmt),
    .word (word[15:0]),
    .px   (px)
  );

  assign pix_valid = busy_q && !err;
  assign red       = pix_valid ? px.r   : '0;
  assign green     = pix_valid ? px.g   : '0;
  assign blue      = pix_valid ? px.b   : '0;
  assign overlay   = pix_valid ? px.ovl : '0;
  assign cfg_err   = err;

endmodule

// File: rtl/dcps_checker.sv
module dcps_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  fmt_code,
  input logic [7:0]  mux_code,
  input logic        big_endian,
  input logic        load_valid,
  input logic [63:0] load_data,
  input logic        load_ready,
  input logic        pix_valid,
  input logic [7:0]  red,
  input logic [7:0]  green,
  input logic [7:0]  blue,
  input logic [3:0]  overlay,
  input logic        cfg_err
);

  // R11
  err_blocks_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (!pix_valid && !load_ready));

  // R11
  err_zero_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (red == 8'd0 && green == 8'd0 && blue == 8'd0 && overlay == 4'd0));

  // R10
  take_then_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_valid && load_ready) |=> (pix_valid || cfg_err));

  // R10
  mid_load_cont_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !load_ready) |=> (pix_valid || cfg_err));

  // R9
  single_lane_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && mux_code == 8'h52) |-> load_ready);

  // R2
  no_ovl_565_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_code == 8'h05) |-> (overlay == 4'd0));

  // R4
  no_ovl_664_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_code == 8'h03) |-> (overlay == 4'd0));

  // R3
  ovl_1bit_1555_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_code == 8'h04) |-> (overlay[3:1] == 3'd0));

  // R12
  widen_4444_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && fmt_code == 8'h01) |->
      (red[7:4] == red[3:0] && green[7:4] == green[3:0] && blue[7:4] == blue[3:0]));

endmodule

bind dc_pixel_serializer dcps_checker u_chk (.*);

// File: tb/sim_dc_pixel_serializer.sv
`timescale 1ns/1ps
module sim_dc_pixel_serializer;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  fmt_code, mux_code;
  logic        big_endian, load_valid;
  logic [63:0] load_data;
  logic        load_ready, pix_valid, cfg_err;
  logic [7:0]  red, green, blue;
  logic [3:0]  overlay;

  always #5 clk = ~clk;

  dc_pixel_serializer u0 (
    .clk(clk), .rst_n(rst_n), .fmt_code(fmt_code), .mux_code(mux_code),
    .big_endian(big_endian), .load_valid(load_valid), .load_data(load_data),
    .load_ready(load_ready), .pix_valid(pix_valid), .red(red), .green(green),
    .blue(blue), .overlay(overlay), .cfg_err(cfg_err)
  );

  int compared   = 0;
  int mismatched = 0;
  int cycles     = 0;
  bit done       = 1'b0;

  logic [27:0] exp_q[$];
  string       tag_q[$];

  function automatic logic [27:0] model(input logic [7:0] f, input logic [15:0] w);
    logic [7:0] r, g, b;
    logic [3:0] o;
    o = 4'd0;
    case (f)
      8'h05: begin r = {w[15:11], w[15:13]}; g = {w[10:5], w[10:9]}; b = {w[4:0], w[4:2]}; end
      8'h04: begin o = {3'd0, w[15]}; r = {w[14:10], w[14:12]}; g = {w[9:5], w[9:7]}; b = {w[4:0], w[4:2]}; end
      8'h03: begin r = {w[15:10], w[15:14]}; g = {w[9:4], w[9:8]}; b = {w[3:0], w[3:0]}; end
      default: begin r = {w[15:12], w[15:12]}; g = {w[11:8], w[11:8]}; b = {w[7:4], w[7:4]}; o = w[3:0]; end
    endcase
    return {r, g, b, o};
  endfunction

  function automatic int lane_count(input logic [7:0] m);
    return (m == 8'h52) ? 1 : (m == 8'h53) ? 2 : 4;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // driver: offers a load, pushes expected pixels when it will be taken
  task automatic send_load(input logic [63:0] d, input string tag);
    int n;
    @(negedge clk);
    load_valid = 1'b1;
    load_data  = d;
    while (!load_ready) @(negedge clk);
    n = lane_count(mux_code);
    for (int k = 0; k < n; k++) begin
      int lane;
      lane = big_endian ? (n - 1 - k) : k;
      exp_q.push_back(model(fmt_code, d[16*lane +: 16]));
      tag_q.push_back(tag);
    end
    @(posedge clk);
    #1 load_valid = 1'b0;
  endtask

  task automatic drain();
    @(negedge clk);
    while (pix_valid) @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && pix_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R10", "unexpected pixel", {red, green, blue, overlay}, 0);
      end else begin
        logic [27:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({red, green, blue, overlay} === e, t, "pixel",
              {4'd0, red, green, blue, overlay}, {4'd0, e});
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !done) begin
      mismatched++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  localparam logic [7:0] FCODES [4] = '{8'h05, 8'h04, 8'h03, 8'h01};
  localparam logic [7:0] MCODES [3] = '{8'h52, 8'h53, 8'h54};

  initial begin
    rst_n = 1'b0; fmt_code = 8'h05; mux_code = 8'h54; big_endian = 1'b0;
    load_valid = 1'b0; load_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check(pix_valid == 1'b0, "R1", "pix_valid after reset", pix_valid, 0);
    repeat (3) @(negedge clk);
    check(load_ready == 1'b1, "R1", "load_ready after reset", load_ready, 1);
    check(cfg_err == 1'b0, "R1", "cfg_err after reset", cfg_err, 0);

    // all layouts x widths x orders
    for (int fi = 0; fi < 4; fi++) begin
      for (int mi = 0; mi < 3; mi++) begin
        for (int be = 0; be < 2; be++) begin
          string ft, tag;
          logic [15:0] k;
          #2;
          fmt_code = FCODES[fi]; mux_code = MCODES[mi]; big_endian = be[0];
          ft  = (fi == 0) ? "R2" : (fi == 1) ? "R3" : (fi == 2) ? "R4" : "R5";
          tag = $sformatf("%s/R6/%s/R12", ft, be ? "R8" : "R7");
          k   = 16'(fi * 16'h1357 + mi * 16'h0F0F + be * 16'h8001);
          send_load(64'h9F3A_6C15_E2B7_0D48 ^ {4{k}}, tag);
          send_load(64'h1234_8765_FFFF_0000 ^ {k, 48'd0}, tag);
          send_load({48'hDEAD_BEEF_CAFE, 16'h0000}, tag);
          send_load({48'h0000_0000_0000, 16'hFFFF}, tag);
          drain();
        end
      end
    end

    // cycle-by-cycle trace of a 4-pixel load
    #2 fmt_code = 8'h05; mux_code = 8'h54; big_endian = 1'b0;
    send_load(64'h1111_2222_3333_4444, "R9/R7");
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(pix_valid == 1'b1, "R10", "pix_valid in load", pix_valid, 1);
      check(load_ready == (i == 3), "R9", "load_ready position", load_ready, (i == 3));
      #2 load_data = 64'hAAAA_BBBB_CCCC_DDDD ^ 64'(i);
    end
    @(negedge clk);
    check(pix_valid == 1'b0, "R10", "pix_valid after last", pix_valid, 0);
    check(exp_q.size() == 0, "R9", "queue drained", exp_q.size(), 0);

    // unsupported codes
    #2 fmt_code = 8'h02;
    @(negedge clk);
    check(cfg_err == 1'b1, "R11", "cfg_err bad fmt", cfg_err, 1);
    check(load_ready == 1'b0, "R11", "load_ready bad fmt", load_ready, 0);
    #2 fmt_code = 8'h05; mux_code = 8'h55;
    @(negedge clk);
    check(cfg_err == 1'b1, "R11", "cfg_err bad mux", cfg_err, 1);
    #2 mux_code = 8'h54;

    // error raised mid-load drops the remaining pixels
    send_load(64'h0F0F_F0F0_5555_AAAA, "R11");
    @(negedge clk);
    #2 mux_code = 8'h99;
    @(negedge clk);
    check(cfg_err == 1'b1, "R11", "cfg_err mid-load", cfg_err, 1);
    check(pix_valid == 1'b0, "R11", "pix_valid mid-load err", pix_valid, 0);
    check({red, green, blue, overlay} == 28'd0, "R11", "outputs zero",
          {4'd0, red, green, blue, overlay}, 0);
    #2 mux_code = 8'h54;
    exp_q.delete();
    tag_q.delete();
    @(negedge clk);
    check(pix_valid == 1'b0, "R11", "dropped pixels stay gone", pix_valid, 0);
    check(load_ready == 1'b1, "R11", "ready after recovery", load_ready, 1);

    repeat (2) @(negedge clk);
    check(exp_q.size() == 0, "R10", "no pixel left unsent", exp_q.size(), 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule